// File: doc/BRIEF.md
# Store-Multiple Double-Register Burst Sequencer

This block takes one 32-bit store-multiple instruction word that names a run of 64-bit floating-point registers. It decodes the word, checks it, and turns it into a stream of 32-bit memory write requests. With the instruction it receives the value of the base address register and the current endianness. It fetches each 64-bit register through a read port with one cycle of latency and sends it out as two word writes at consecutive addresses. The endianness setting decides which half goes first. Each write request waits on a valid/ready handshake.

Two addressing modes are supported. In ascending mode the burst starts at the base. In descending mode the burst starts below the base, and writing the base back is mandatory. When writeback is requested, the updated base value and its register number come out with a write-enable in the final cycle of the operation. An encoding that is outside this variant, undefined or unpredictable produces no memory traffic and no writeback. Instead, the done pulse carries exactly one error flag.

Top module: `stm_burst_seq`

## Requirements
- R1: The word is treated as another encoding, and only `err_other` is raised at done, when any of the following holds: bits 31:28 are 1111, bits 27:25 are not 110, bit 20 is 1, bits 11:8 are not 1011, bit 0 is 0, bits {24,23,21} (P,U,W) are 000, or P=1 with W=0.
- R2: Otherwise, when P equals U and W is 1, only `err_undef` is raised at done.
- R3: Otherwise, let count = bits 7:1 and first = {bit 22, bits 15:12}. Only `err_unpred` is raised when any of these holds: count is 0, count exceeds 16, first+count exceeds 16, or bits 19:16 are 15 while W is 1.
- R4: A flagged word causes no memory request and no writeback. `done` is high for exactly one cycle, and at most one error flag is set at any time.
- R5: Write k (counting from 0) goes to start + 8*(k/2) + 4*(k%2). Start is the base value when U=1, and the base minus {bits 7:0, 2'b00} when U=0.
- R6: For each register, the low half (bits 31:0) is written first when `big_endian` is 0. The high half (bits 63:32) is written first when `big_endian` is 1.
- R7: When W=1, `wb_en` is high together with `done`. At that time `wb_rn` equals bits 19:16 and `wb_value` equals the base plus {imm8,2'b00} when U=1, or the base minus it when U=0. When W=0, `wb_en` stays low.
- R8: Registers are read in ascending order, starting at `first`, through `rf_rd_idx`. Data appears on `rf_rd_data` one cycle after `rf_rd_en`.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R10: `instr_ready` is high only when the block is idle. With `mem_ready` held high, the 2*count writes take place in consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 32 | Store-multiple instruction word |
| base_val | input | 32 | Value of the base register, sampled on accept |
| big_endian | input | 1 | Endianness for the operation, sampled on accept |
| instr_ready | output | 1 | Block is idle and takes a word this cycle |
| rf_rd_en | output | 1 | Register file read strobe |
| rf_rd_idx | output | 5 | Register index to read |
| rf_rd_data | input | 64 | Read data, one cycle after the strobe |
| mem_valid | output | 1 | Word write request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Write address |
| mem_data | output | 32 | Write data |
| wb_en | output | 1 | Base writeback enable |
| wb_rn | output | 4 | Base register number to update |
| wb_value | output | 32 | Updated base value |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_undef | output | 1 | Undefined encoding, valid with done |
| err_unpred | output | 1 | Unpredictable encoding, valid with done |
| err_other | output | 1 | Encoding outside this variant, valid with done |

## Verification
The bench drives words that sit on the decode boundaries: first+count exactly 16 and one past it, a count of 17, a zero count, and base register 15 with and without writeback. A design with an off-by-one limit would accept a bad list or reject a legal one. The bench also checks descending mode with the full sixteen registers under random stalls. A wrong start offset or a dropped second word would shift every address that follows. It checks big-endian ordering, because swapped halves show up as exchanged data at addr and addr+4. It runs unstalled bursts to catch a prefetch that is late or that overwrites the current register, which would show up as a gap between writes or as data repeated from the wrong register.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int INSTR_W   = 32;
  localparam int ADDR_W    = 32;
  localparam int REG_W     = 64;
  localparam int WORD_W    = REG_W / 2;
  localparam int IDX_W     = 5;
  localparam int RN_W      = 4;
  localparam int CNT_W     = 7;
  localparam int MAX_LIST  = 16;
  localparam int BANK_SPAN = 16;
  localparam int FILE_SPAN = 32;
  localparam int PC_NUM    = 15;
  localparam int STEP_REG  = REG_W / 8;
  localparam int STEP_WORD = WORD_W / 8;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_FIN} seq_st_t;

  typedef struct packed {
    logic             up;
    logic             wback;
    logic [RN_W-1:0]  rn;
    logic [IDX_W-1:0] first;
    logic [7:0]       imm8;
    logic [IDX_W-1:0] count;
    logic             is_other;
    logic             is_undef;
    logic             is_unpred;
  } stm_dec_t;

  function automatic logic [ADDR_W-1:0] byte_span(input logic [7:0] imm8);
    return {{(ADDR_W-10){1'b0}}, imm8, 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] first_addr(input logic [ADDR_W-1:0] base,
                                                   input logic up, input logic [7:0] imm8);
    return up ? base : base - byte_span(imm8);
  endfunction

  function automatic logic [ADDR_W-1:0] new_base(input logic [ADDR_W-1:0] base,
                                                 input logic up, input logic [7:0] imm8);
    return up ? base + byte_span(imm8) : base - byte_span(imm8);
  endfunction
endpackage

// File: rtl/stm_decode.sv
module stm_decode
  import stm_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output stm_dec_t           dec
);
  logic             p_bit;
  logic [CNT_W-1:0] raw_cnt;
  logic [7:0]       span_end;

  always_comb begin
    p_bit    = instr[24];
    raw_cnt  = instr[7:1];
    dec.up    = instr[23];
    dec.wback = instr[21];
    dec.rn    = instr[19:16];
    dec.first = {instr[22], instr[15:12]};
    dec.imm8  = instr[7:0];
    dec.count = raw_cnt[IDX_W-1:0];
    span_end  = {3'b000, dec.first} + {1'b0, raw_cnt};
    dec.is_other = (instr[31:28] == 4'hF) || (instr[27:25] != 3'b110) || instr[20] ||
                   (instr[11:8] != 4'b1011) || !instr[0] ||
                   (!p_bit && !dec.up && !dec.wback) || (p_bit && !dec.wback);
    dec.is_undef = (p_bit == dec.up) && dec.wback;
    dec.is_unpred = (raw_cnt == '0) || (raw_cnt > CNT_W'(MAX_LIST)) ||
                    (span_end > 8'(FILE_SPAN)) ||
                    (instr[0] && (span_end > 8'(BANK_SPAN))) ||
                    ((dec.rn == RN_W'(PC_NUM)) && dec.wback);
  end
endmodule

// File: rtl/stm_word_sel.sv
module stm_word_sel
  import stm_pkg::*;
(
  input  logic [REG_W-1:0]  reg_val,
  input  logic              second,
  input  logic              big_end,
  output logic [WORD_W-1:0] word
);
  always_comb word = (second ^ big_end) ? reg_val[REG_W-1:WORD_W] : reg_val[WORD_W-1:0];
endmodule

// File: rtl/stm_seq.sv
module stm_seq
  import stm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic              start_bad,
  input  logic [2:0]        bad_flags,
  input  stm_dec_t          dec,
  input  logic [ADDR_W-1:0] base,
  input  logic              big_end_in,
  input  logic              mem_ready,
  input  logic [REG_W-1:0]  rf_rd_data,
  output logic              idle,
  output logic              rf_rd_en,
  output logic [IDX_W-1:0]  rf_rd_idx,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              hi_phase,
  output logic              big_end,
  output logic [REG_W-1:0]  cur_reg,
  output logic              done,
  output logic [2:0]        err_flags,
  output logic              wb_en,
  output logic [RN_W-1:0]   wb_rn,
  output logic [ADDR_W-1:0] wb_value
);
  seq_st_t          st;
  logic [ADDR_W-1:0] addr_q, wbv_q;
  logic [IDX_W-1:0]  cnt_q, idx_q;
  logic [REG_W-1:0]  hold_q;
  logic              rdv_q, w_q, last_reg;
  logic [2:0]        errs_q;

  assign idle      = (st == S_IDLE);
  assign hi_phase  = (st == S_HI);
  assign mem_valid = (st == S_LO) || (st == S_HI);
  assign last_reg  = (cnt_q == IDX_W'(1));
  assign mem_addr  = hi_phase ? addr_q + ADDR_W'(STEP_WORD) : addr_q;
  assign cur_reg   = rdv_q ? rf_rd_data : hold_q;
  assign rf_rd_en  = (idle && start_ok) || (hi_phase && mem_ready && !last_reg);
  assign rf_rd_idx = idle ? dec.first : idx_q + IDX_W'(1);
  assign done      = (st == S_FIN);
  assign err_flags = done ? errs_q : 3'b000;
  assign wb_en     = done && w_q;
  assign wb_value  = wbv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; addr_q <= '0; wbv_q <= '0; cnt_q <= '0; idx_q <= '0;
      hold_q <= '0; rdv_q <= 1'b0; w_q <= 1'b0; errs_q <= '0; wb_rn <= '0; big_end <= 1'b0;
    end else begin
      rdv_q <= rf_rd_en;
      if (rdv_q) hold_q <= rf_rd_data;
      unique case (st)
        S_IDLE: begin
          if (start_ok) begin
            st      <= S_LO;
            addr_q  <= first_addr(base, dec.up, dec.imm8);
            wbv_q   <= new_base(base, dec.up, dec.imm8);
            cnt_q   <= dec.count;
            idx_q   <= dec.first;
            w_q     <= dec.wback;
            wb_rn   <= dec.rn;
            big_end <= big_end_in;
            errs_q  <= '0;
          end else if (start_bad) begin
            st     <= S_FIN;
            w_q    <= 1'b0;
            errs_q <= bad_flags;
          end
        end
        S_LO: if (mem_ready) st <= S_HI;
        S_HI: begin
          if (mem_ready) begin
            addr_q <= addr_q + ADDR_W'(STEP_REG);
            if (last_reg) st <= S_FIN;
            else begin
              st    <= S_LO;
              cnt_q <= cnt_q - IDX_W'(1);
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stm_burst_seq.sv
module stm_burst_seq
  import stm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_valid,
  input  logic [INSTR_W-1:0]  instr_word,
  input  logic [ADDR_W-1:0]   base_val,
  input  logic                big_endian,
  output logic                instr_ready,
  output logic                rf_rd_en,
  output logic [IDX_W-1:0]    rf_rd_idx,
  input  logic [REG_W-1:0]    rf_rd_data,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_data,
  output logic                wb_en,
  output logic [RN_W-1:0]     wb_rn,
  output logic [ADDR_W-1:0]   wb_value,
  output logic                done,
  output logic                err_undef,
  output logic                err_unpred,
  output logic                err_other
);
  stm_dec_t         dec;
  logic             accept, start_ok, start_bad, hi_phase, word_fire, big_end;
  logic [2:0]       bad_flags, err_flags;
  logic [REG_W-1:0] cur_reg;

  stm_decode u_dec (.instr(instr_word), .dec(dec));

  // Priority: foreign encoding, then undefined, then unpredictable.
  assign bad_flags[2] = dec.is_other;
  assign bad_flags[1] = !dec.is_other && dec.is_undef;
  assign bad_flags[0] = !dec.is_other && !dec.is_undef && dec.is_unpred;
  assign accept    = instr_valid && instr_ready;
  assign start_bad = accept && (bad_flags != 3'b000);
  assign start_ok  = accept && (bad_flags == 3'b000);
  assign word_fire = mem_valid && mem_ready;

  stm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .start_bad(start_bad),
    .bad_flags(bad_flags), .dec(dec), .base(base_val), .big_end_in(big_endian),
    .mem_ready(mem_ready), .rf_rd_data(rf_rd_data), .idle(instr_ready),
    .rf_rd_en(rf_rd_en), .rf_rd_idx(rf_rd_idx), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .hi_phase(hi_phase), .big_end(big_end), .cur_reg(cur_reg),
    .done(done), .err_flags(err_flags), .wb_en(wb_en), .wb_rn(wb_rn), .wb_value(wb_value)
  );

  stm_word_sel u_sel (.reg_val(cur_reg), .second(hi_phase), .big_end(big_end), .word(mem_data));

  assign err_other  = err_flags[2];
  assign err_undef  = err_flags[1];
  assign err_unpred = err_flags[0];
endmodule

// File: rtl/stm_burst_seq_chk.sv
module stm_burst_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_ready,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_data,
  input logic        hi_phase,
  input logic        word_fire,
  input logic        done,
  input logic        wb_en,
  input logic        err_undef,
  input logic        err_unpred,
  input logic        err_other
);
  logic any_err;
  assign any_err = err_undef || err_unpred || err_other;

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  p_second_word_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_fire && !hi_phase |=> mem_valid && hi_phase && (mem_addr == $past(mem_addr) + 32'd4));
  p_err_no_traffic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |-> !mem_valid && !wb_en && done);
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_flag_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_undef, err_unpred, err_other}));
  p_wb_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || done) |-> !instr_ready);
endmodule

bind stm_burst_seq stm_burst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_ready(instr_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .hi_phase(hi_phase),
  .word_fire(word_fire), .done(done), .wb_en(wb_en), .err_undef(err_undef),
  .err_unpred(err_unpred), .err_other(err_other)
);

// File: tb/stm_burst_seq_tb_top.sv
`timescale 1ns/1ps
module stm_burst_seq_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        instr_valid = 1'b0, big_endian = 1'b0, mem_ready = 1'b1;
  logic [31:0] instr_word = '0, base_val = '0;
  logic        instr_ready, rf_rd_en, mem_valid, wb_en, done, err_undef, err_unpred, err_other;
  logic [4:0]  rf_rd_idx;
  logic [63:0] rf_rd_data = '0;
  logic [31:0] mem_addr, mem_data, wb_value;
  logic [3:0]  wb_rn;

  int checks = 0, failures = 0, cyc = 0, wr_n = 0;
  logic [31:0] wr_addr [64];
  logic [31:0] wr_data [64];
  int          wr_cyc  [64];
  logic        stall_en = 1'b0, ended = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr, prev_data;

  stm_burst_seq dut_i (.*);

  always #5 clk = ~clk;

  function automatic logic [63:0] rfv(input logic [4:0] k);
    return {32'hC000_0000 | (32'(k) * 32'h0001_0101), 32'h3000_0000 | (32'(k) * 32'h0002_0003)};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rf_rd_data <= rf_rd_en ? rfv(rf_rd_idx) : 64'hBAD0_BAD0_BAD0_BAD0;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready <= stall_en ? lfsr[3] : 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (prev_stall) check(mem_valid && mem_addr == prev_addr && mem_data == prev_data,
                          "R9 request held", mem_addr, prev_addr);
    prev_stall = mem_valid && !mem_ready;
    prev_addr = mem_addr; prev_data = mem_data;
    if (mem_valid && mem_ready && wr_n < 64) begin
      wr_addr[wr_n] = mem_addr; wr_data[wr_n] = mem_data; wr_cyc[wr_n] = cyc; wr_n++;
    end
  end

  function automatic logic [31:0] mk(input bit p, input bit u, input bit w, input logic [4:0] d,
                                     input logic [3:0] rn, input logic [7:0] imm8);
    return {4'hE, 3'b110, p, u, d[4], w, 1'b0, rn, d[3:0], 4'b1011, imm8};
  endfunction

  task automatic run_case(input string name, input logic [31:0] iw, input logic [31:0] base,
                          input bit be, input bit stall, input bit gapless);
    bit p, u, w, oth, und, unp, bad;
    int cnt, d, guard;
    logic [31:0] start, expw;
    logic [63:0] rv;
    p = iw[24]; u = iw[23]; w = iw[21]; cnt = int'(iw[7:1]); d = int'({iw[22], iw[15:12]});
    oth = (iw[31:28] == 4'hF) || (iw[27:25] != 3'b110) || iw[20] || (iw[11:8] != 4'hB) ||
          !iw[0] || (!p && !u && !w) || (p && !w);
    und = !oth && (p == u) && w;
    unp = !oth && !und && (cnt == 0 || cnt > 16 || d + cnt > 16 || (iw[19:16] == 4'd15 && w));
    bad = oth || und || unp;
    while (!instr_ready) @(negedge clk);
    stall_en = stall; wr_n = 0;
    instr_word = iw; base_val = base; big_endian = be; instr_valid = 1'b1;
    @(posedge clk); #1 instr_valid = 1'b0; big_endian = ~be; base_val = 32'hFFFF_0000;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!done && guard < 3000);
    check(done, {name, " R4 done reached"}, 32'(done), 1);
    check(err_other == oth, {name, " R1 other flag"}, 32'(err_other), 32'(oth));
    check(err_undef == und, {name, " R2 undef flag"}, 32'(err_undef), 32'(und));
    check(err_unpred == unp, {name, " R3 unpred flag"}, 32'(err_unpred), 32'(unp));
    if (bad) begin
      check(wr_n == 0, {name, " R4 no writes"}, 32'(wr_n), 0);
      check(!wb_en, {name, " R4 no writeback"}, 32'(wb_en), 0);
    end else begin
      start = u ? base : base - {22'd0, iw[7:0], 2'b00};
      check(wr_n == 2 * cnt, {name, " R10 write count"}, 32'(wr_n), 32'(2 * cnt));
      for (int k = 0; k < wr_n && k < 2 * cnt; k++) begin
        rv = rfv(5'(d + k / 2));
        expw = ((k % 2 == 1) ^ be) ? rv[63:32] : rv[31:0];
        check(wr_addr[k] == start + 32'(8 * (k / 2) + 4 * (k % 2)), {name, " R5 address"},
              wr_addr[k], start + 32'(8 * (k / 2) + 4 * (k % 2)));
        check(wr_data[k] == expw, {name, " R6 R8 data order"}, wr_data[k], expw);
      end
      if (gapless && wr_n > 0)
        check(wr_cyc[wr_n-1] - wr_cyc[0] == wr_n - 1, {name, " R10 no bubbles"},
              32'(wr_cyc[wr_n-1] - wr_cyc[0]), 32'(wr_n - 1));
      check(wb_en == w, {name, " R7 wb enable"}, 32'(wb_en), 32'(w));
      if (w) begin
        expw = u ? base + {22'd0, iw[7:0], 2'b00} : base - {22'd0, iw[7:0], 2'b00};
        check(wb_value == expw, {name, " R7 wb value"}, wb_value, expw);
        check(wb_rn == iw[19:16], {name, " R7 wb reg"}, 32'(wb_rn), 32'(iw[19:16]));
      end
    end
    @(negedge clk);
    check(!done && !wb_en, {name, " R4 done one cycle"}, 32'(done), 0);
    check(instr_ready, {name, " R10 idle again"}, 32'(instr_ready), 1);
    stall_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(instr_ready && !mem_valid && !done && !wb_en && !rf_rd_en, "R10 reset state",
          {27'd0, instr_ready, mem_valid, done, wb_en, rf_rd_en}, 32'h10);
  endtask

  task automatic t_ascending();
    run_case("ia_le", mk(0, 1, 0, 5'd2, 4'd3, 8'd7), 32'h0000_1000, 1'b0, 1'b0, 1'b1);
    run_case("ia_be_wb_stall", mk(0, 1, 1, 5'd4, 4'd6, 8'd9), 32'h2000_0100, 1'b1, 1'b1, 1'b0);
    run_case("ia_pc_nowb", mk(0, 1, 0, 5'd15, 4'd15, 8'd3), 32'h0000_8000, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_descending();
    run_case("db_full_stall", mk(1, 0, 1, 5'd0, 4'd13, 8'd33), 32'h0004_0000, 1'b0, 1'b1, 1'b0);
    run_case("db_be_gapless", mk(1, 0, 1, 5'd8, 4'd1, 8'd17), 32'h0000_0200, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_undef();
    run_case("undef_111", mk(1, 1, 1, 5'd0, 4'd2, 8'd5), 32'h100, 1'b0, 1'b0, 1'b0);
    run_case("undef_001", mk(0, 0, 1, 5'd0, 4'd2, 8'd5), 32'h100, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_other();
    run_case("other_000", mk(0, 0, 0, 5'd0, 4'd2, 8'd5), 32'h100, 1'b0, 1'b0, 1'b0);
    run_case("other_p1w0", mk(1, 0, 0, 5'd0, 4'd2, 8'd5), 32'h100, 1'b0, 1'b0, 1'b0);
    run_case("other_even_imm", mk(0, 1, 0, 5'd0, 4'd2, 8'd4), 32'h100, 1'b0, 1'b0, 1'b0);
    run_case("other_coproc", mk(0, 1, 0, 5'd0, 4'd2, 8'd5) ^ 32'h0000_0100, 32'h100, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_unpred();
    run_case("unp_zero", mk(0, 1, 0, 5'd0, 4'd2, 8'd1), 32'h100, 1'b0, 1'b0, 1'b0);
    run_case("unp_bank", mk(0, 1, 0, 5'd10, 4'd2, 8'd15), 32'h100, 1'b0, 1'b0, 1'b0);
    run_case("unp_17", mk(0, 1, 0, 5'd0, 4'd2, 8'd35), 32'h100, 1'b0, 1'b0, 1'b0);
    run_case("unp_pc_wb", mk(0, 1, 1, 5'd0, 4'd15, 8'd5), 32'h100, 1'b0, 1'b0, 1'b0);
    run_case("edge_16_ok", mk(0, 1, 1, 5'd14, 4'd0, 8'd5), 32'hFFFF_FFF0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #(10 * 150000);
    if (!ended) begin
      ended = 1'b1; checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ascending();
    t_descending();
    t_undef();
    t_other();
    t_unpred();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule